// File: doc/BRIEF.md
# Saturating Arithmetic Unit

This block is a 32-bit arithmetic unit whose results clamp to the nearest representable value instead of wrapping. It provides signed and unsigned add and subtract, signed doubling, and a wrapping signed add that only reports overflow. It can also narrow a value to a selectable bit width, either as one full word or as two packed 16-bit halves. The result path is purely combinational.

The block also holds a sticky saturation flag. Any clamping event, and a signed overflow in the wrapping add, sets this flag on the clock edge where the operation is enabled. Only arithmetic never clears it. A dedicated clear input clears it, and a synchronous reset puts it to 0. The instruction decoder that drives it chooses an operation code, presents the operands, and pulses the enable for each executed operation.

Top module: `sat_alu`

## Requirements
- R1: Operation code 0 (signed add) returns the sum. When both operands have the same sign and the sum's sign differs from the first operand, it instead returns 0x7FFFFFFF if the first operand is non-negative, or 0x80000000 if it is negative, and raises `sat_hit`.
- R2: Operation code 1 (signed subtract) returns A minus B. When the operands differ in sign and the difference's sign differs from A, it clamps to 0x7FFFFFFF or 0x80000000 according to the sign of A and raises `sat_hit`.
- R3: Operation code 2 (signed doubling of A) returns 0x7FFFFFFF with `sat_hit` for A at or above 0x40000000 as signed. It returns 0x80000000 with `sat_hit` for A at or below 0xC0000000 as signed, and A shifted left by one otherwise.
- R4: Operation code 3 (unsigned add) returns 0xFFFFFFFF with `sat_hit` on carry out. Operation code 4 (unsigned subtract) returns 0 with `sat_hit` when B exceeds A. Otherwise each returns the plain result.
- R5: Operation code 5 (wrapping signed add) always returns the 32-bit wrapped sum, and raises `sat_hit` exactly when the signed sum overflows.
- R6: Operation code 6 narrows A, as a signed value, to the range [-(2^n), 2^n - 1], where n is `sat_width`. A value outside that range is replaced by the nearer limit and raises `sat_hit`.
- R7: Operation code 7 narrows A, read as a signed value, to the range [0, 2^n - 1]. Negative values give 0 and values above the range give 2^n - 1, both raising `sat_hit`.
- R8: Operation codes 8 (signed) and 9 (unsigned) apply the rules of R6 and R7 separately to A[15:0] and A[31:16], each sign-extended from 16 bits. The two low 16-bit results are packed back into one word in the same half positions. `sat_hit` is raised if either half clamps.
- R9: `q_flag` becomes 1 on the clock edge after any cycle with `op_en` high and `sat_hit` high. Once set, only R10 clears it. With `op_en` low, a clamping result does not change it. Unused codes 10 to 15 return 0 without `sat_hit`.
- R10: `q_flag` is 0 after reset. `q_clr` high clears it at the next edge, unless a flag-setting event from R9 occurs in the same cycle, in which case the flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_en | input | 1 | Operation executes this cycle; gates flag update |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First operand / value to narrow |
| opnd_b | input | 32 | Second operand |
| sat_width | input | 5 | Narrowing width n for codes 6 to 9 |
| q_clr | input | 1 | Clear request for the sticky flag |
| result | output | 32 | Combinational result |
| sat_hit | output | 1 | Combinational clamp/overflow event |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
Every cycle, the assertions check the sticky flag's rules: it is set after an enabled event, held while no clear is present, cleared by a lone clear, and never raised without cause. They also check that a clamped signed result carries one of the two extreme values, that an unsigned add clamp is all ones, that a clamped narrowing keeps the input's sign, and that the wrapping add always returns the plain sum. The exact thresholds can only be shown by the bench's directed scenarios. These include operand pairs just inside and just outside each overflow boundary, the doubling edges at ±2^30, and the narrowing limits at widths 1, 8, 16 and 31 on each side. The bench also covers the independent treatment of the two halves.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int DW     = 32;
  localparam int HALF_W = DW / 2;
  localparam int LANES  = DW / HALF_W;
  localparam int NW     = $clog2(DW);

  typedef enum logic [3:0] {
    OP_SADD   = 4'd0,
    OP_SSUB   = 4'd1,
    OP_SDBL   = 4'd2,
    OP_UADD   = 4'd3,
    OP_USUB   = 4'd4,
    OP_WADD   = 4'd5,
    OP_NSAT   = 4'd6,
    OP_NUSAT  = 4'd7,
    OP_NSAT2  = 4'd8,
    OP_NUSAT2 = 4'd9
  } sat_op_e;

  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  // Each function returns {event, value}.
  function automatic logic [DW:0] f_sadd(logic [DW-1:0] a, logic [DW-1:0] b);
    logic [DW-1:0] s;
    s = a + b;
    if ((a[DW-1] == b[DW-1]) && (s[DW-1] != a[DW-1]))
      return {1'b1, a[DW-1] ? SMIN : SMAX};
    return {1'b0, s};
  endfunction

  function automatic logic [DW:0] f_ssub(logic [DW-1:0] a, logic [DW-1:0] b);
    logic [DW-1:0] d;
    d = a - b;
    if ((a[DW-1] != b[DW-1]) && (d[DW-1] != a[DW-1]))
      return {1'b1, a[DW-1] ? SMIN : SMAX};
    return {1'b0, d};
  endfunction

  function automatic logic [DW:0] f_sdbl(logic [DW-1:0] a);
    if (a[DW-1:DW-2] == 2'b01)
      return {1'b1, SMAX};
    if ((a[DW-1:DW-2] == 2'b10) || (a == {2'b11, {(DW-2){1'b0}}}))
      return {1'b1, SMIN};
    return {1'b0, a[DW-2:0], 1'b0};
  endfunction

  function automatic logic [DW:0] f_uadd(logic [DW-1:0] a, logic [DW-1:0] b);
    logic [DW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s[DW]) return {1'b1, {DW{1'b1}}};
    return {1'b0, s[DW-1:0]};
  endfunction

  function automatic logic [DW:0] f_usub(logic [DW-1:0] a, logic [DW-1:0] b);
    if (b > a) return {1'b1, {DW{1'b0}}};
    return {1'b0, a - b};
  endfunction

  function automatic logic [DW:0] f_ssat(logic [DW-1:0] v, logic [NW-1:0] n);
    logic [DW-1:0] top;
    logic [DW-1:0] mask;
    top  = $signed(v) >>> n;
    mask = (DW'(1) << n) - DW'(1);
    if (!top[DW-1] && (|top)) return {1'b1, mask};
    if (top[DW-1] && !(&top)) return {1'b1, ~mask};
    return {1'b0, v};
  endfunction

  function automatic logic [DW:0] f_usat(logic [DW-1:0] v, logic [NW-1:0] n);
    logic [DW-1:0] mask;
    mask = (DW'(1) << n) - DW'(1);
    if (v[DW-1]) return {1'b1, {DW{1'b0}}};
    if (v > mask) return {1'b1, mask};
    return {1'b0, v};
  endfunction
endpackage

// File: rtl/sat_arith.sv
module sat_arith
  import sat_pkg::*;
(
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output logic          hit
);
  logic [DW:0] r;
  logic [DW:0] wrap;

  always_comb begin
    wrap = f_sadd(a, b);
    unique case (op)
      OP_SADD: r = f_sadd(a, b);
      OP_SSUB: r = f_ssub(a, b);
      OP_SDBL: r = f_sdbl(a);
      OP_UADD: r = f_uadd(a, b);
      OP_USUB: r = f_usub(a, b);
      OP_WADD: r = {wrap[DW], a + b};
      default: r = '0;
    endcase
    res = r[DW-1:0];
    hit = r[DW];
  end
endmodule

// File: rtl/sat_narrow.sv
module sat_narrow
  import sat_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  logic [LANE_W-1:0] val,
  input  logic [NW-1:0]     width,
  input  logic              is_signed,
  output logic [LANE_W-1:0] res,
  output logic              hit
);
  logic [DW-1:0] ext;
  logic [DW:0]   r;

  always_comb begin
    ext = DW'($signed(val));
    r   = is_signed ? f_ssat(ext, width) : f_usat(ext, width);
    hit = r[DW];
    res = r[LANE_W-1:0];
  end
endmodule

// File: rtl/sat_sticky.sv
module sat_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= (q & ~clr) | set;
  end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_en,
  input  logic [3:0]    op_sel,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic [NW-1:0] sat_width,
  input  logic          q_clr,
  output logic [DW-1:0] result,
  output logic          sat_hit,
  output logic          q_flag
);
  logic [DW-1:0]     arith_res;
  logic              arith_hit;
  logic [DW-1:0]     full_res;
  logic              full_hit;
  logic [DW-1:0]     pair_res;
  logic [LANES-1:0]  lane_hit;
  logic              is_word_op;
  logic              is_full_op;
  logic              is_pair_op;
  logic              q_set;

  assign is_word_op = (op_sel <= OP_WADD);
  assign is_full_op = (op_sel == OP_NSAT)  || (op_sel == OP_NUSAT);
  assign is_pair_op = (op_sel == OP_NSAT2) || (op_sel == OP_NUSAT2);

  sat_arith u_arith (
    .op (op_sel), .a (opnd_a), .b (opnd_b), .res (arith_res), .hit (arith_hit)
  );

  sat_narrow #(.LANE_W(DW)) u_full (
    .val (opnd_a), .width (sat_width), .is_signed (op_sel == OP_NSAT),
    .res (full_res), .hit (full_hit)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sat_narrow #(.LANE_W(HALF_W)) u_half (
      .val       (opnd_a[i*HALF_W +: HALF_W]),
      .width     (sat_width),
      .is_signed (op_sel == OP_NSAT2),
      .res       (pair_res[i*HALF_W +: HALF_W]),
      .hit       (lane_hit[i])
    );
  end

  always_comb begin
    if (is_word_op)      begin result = arith_res; sat_hit = arith_hit; end
    else if (is_full_op) begin result = full_res;  sat_hit = full_hit;  end
    else if (is_pair_op) begin result = pair_res;  sat_hit = |lane_hit; end
    else                 begin result = '0;        sat_hit = 1'b0;      end
  end

  assign q_set = op_en & sat_hit;

  sat_sticky u_q (.clk (clk), .rst_n (rst_n), .set (q_set), .clr (q_clr), .q (q_flag));

  // R9: an enabled event always shows up in the flag.
  a_r9_event_sets_q: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && sat_hit) |=> q_flag);
  // R9: the flag holds while no clear arrives.
  a_r9_q_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (q_flag && !q_clr) |=> q_flag);
  // R9: the flag is never raised without an enabled event.
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_flag && !(op_en && sat_hit)) |=> !q_flag);
  // R10: a lone clear empties the flag.
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (q_clr && !(op_en && sat_hit)) |=> !q_flag);
  // R1, R2: clamped signed results sit at an extreme.
  a_r1_clamp_extreme: assert property (@(posedge clk) disable iff (!rst_n)
    (((op_sel == OP_SADD) || (op_sel == OP_SSUB)) && arith_hit)
      |-> ((result == SMAX) || (result == SMIN)));
  // R4: unsigned add clamp is all ones.
  a_r4_uadd_ones: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_sel == OP_UADD) && sat_hit) |-> (&result));
  // R6: a signed narrowing clamp keeps the sign of the input.
  a_r6_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_sel == OP_NSAT) && full_hit) |-> (result[DW-1] == opnd_a[DW-1]));
  // R5: the wrapping add never clamps.
  a_r5_wrap_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_WADD) |-> (result == opnd_a + opnd_b));
endmodule

// File: tb/sat_alu_tb.sv
module sat_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_en = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [4:0]  sat_width = '0;
  logic        q_clr = 1'b0;
  logic [31:0] result;
  logic        sat_hit;
  logic        q_flag;

  int checks = 0;
  int errors = 0;
  bit q_model = 1'b0;

  localparam longint SMAXL = 64'sd2147483647;
  localparam longint SMINL = -64'sd2147483648;
  localparam longint UMAXL = 64'sd4294967295;

  sat_alu u_dut (
    .clk (clk), .rst_n (rst_n), .op_en (op_en), .op_sel (op_sel),
    .opnd_a (opnd_a), .opnd_b (opnd_b), .sat_width (sat_width),
    .q_clr (q_clr), .result (result), .sat_hit (sat_hit), .q_flag (q_flag)
  );

  always #10 clk = ~clk;

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [32:0] clampl(longint v, longint lo, longint hi);
    if (v > hi) return {1'b1, hi[31:0]};
    if (v < lo) return {1'b1, lo[31:0]};
    return {1'b0, v[31:0]};
  endfunction

  function automatic logic [32:0] model(logic [3:0] op, logic [31:0] a,
                                        logic [31:0] b, logic [4:0] w);
    longint sa, sb, ua, ub, lim, h0, h1, s;
    logic [32:0] r0, r1;
    sa  = longint'($signed(a));
    sb  = longint'($signed(b));
    ua  = longint'(a);
    ub  = longint'(b);
    lim = longint'(1) << w;
    case (op)
      4'd0: return clampl(sa + sb, SMINL, SMAXL);
      4'd1: return clampl(sa - sb, SMINL, SMAXL);
      4'd2: begin
        if (sa >= 64'sd1073741824)  return {1'b1, 32'h7FFFFFFF};
        if (sa <= -64'sd1073741824) return {1'b1, 32'h80000000};
        s = sa * 2;
        return {1'b0, s[31:0]};
      end
      4'd3: return clampl(ua + ub, 0, UMAXL);
      4'd4: return clampl(ua - ub, 0, UMAXL);
      4'd5: begin
        s = sa + sb;
        return {(s > SMAXL) || (s < SMINL), a + b};
      end
      4'd6: return clampl(sa, -lim, lim - 1);
      4'd7: return clampl(sa, 0, lim - 1);
      4'd8, 4'd9: begin
        h0 = longint'($signed(a[15:0]));
        h1 = longint'($signed(a[31:16]));
        r0 = (op == 4'd8) ? clampl(h0, -lim, lim - 1) : clampl(h0, 0, lim - 1);
        r1 = (op == 4'd8) ? clampl(h1, -lim, lim - 1) : clampl(h1, 0, lim - 1);
        return {r0[32] | r1[32], r1[15:0], r0[15:0]};
      end
      default: return 33'b0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // Drive one enabled operation, check result, event and the flag after the edge.
  task automatic run_op(string tag, logic [3:0] op, logic [31:0] a,
                        logic [31:0] b, logic [4:0] w);
    logic [32:0] e;
    e = model(op, a, b, w);
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; sat_width = w; op_en = 1'b1;
    #1;
    chk({tag, " result"}, result, e[31:0]);
    chk({tag, " event"}, {31'b0, sat_hit}, {31'b0, e[32]});
    @(negedge clk);
    op_en = 1'b0;
    q_model = q_model | e[32];
    #1;
    chk({tag, " flag"}, {31'b0, q_flag}, {31'b0, q_model});
  endtask

  task automatic clear_q();
    @(negedge clk); q_clr = 1'b1;
    @(negedge clk); q_clr = 1'b0; q_model = 1'b0;
    #1 chk("R10 clear", {31'b0, q_flag}, 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R10 reset flag", {31'b0, q_flag}, 32'd0);
  endtask

  task automatic t_sadd();
    run_op("R1 small", 4'd0, 32'd5, 32'hFFFFFFFD, 0);
    run_op("R1 edge max", 4'd0, 32'h7FFFFFFE, 32'd1, 0);
    clear_q();
    run_op("R1 pos ovf", 4'd0, 32'h7FFFFFFF, 32'd1, 0);
    run_op("R1 neg edge", 4'd0, 32'h80000001, 32'hFFFFFFFF, 0);
    run_op("R1 neg ovf", 4'd0, 32'h80000000, 32'hFFFFFFFF, 0);
    run_op("R1 mixed", 4'd0, 32'h7FFFFFFF, 32'h80000000, 0);
    clear_q();
  endtask

  task automatic t_ssub();
    run_op("R2 edge", 4'd1, 32'h7FFFFFFE, 32'hFFFFFFFF, 0);
    run_op("R2 pos ovf", 4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 0);
    run_op("R2 neg ovf", 4'd1, 32'h80000000, 32'd1, 0);
    run_op("R2 zero minus min", 4'd1, 32'd0, 32'h80000000, 0);
    run_op("R2 same sign", 4'd1, 32'h80000000, 32'h80000000, 0);
    clear_q();
  endtask

  task automatic t_dbl();
    run_op("R3 below top", 4'd2, 32'h3FFFFFFF, 0, 0);
    run_op("R3 top", 4'd2, 32'h40000000, 0, 0);
    clear_q();
    run_op("R3 above bottom", 4'd2, 32'hC0000001, 0, 0);
    run_op("R3 bottom", 4'd2, 32'hC0000000, 0, 0);
    run_op("R3 min", 4'd2, 32'h80000000, 0, 0);
    clear_q();
  endtask

  task automatic t_unsigned();
    run_op("R4 add edge", 4'd3, 32'hFFFFFFFE, 32'd1, 0);
    run_op("R4 add carry", 4'd3, 32'hFFFFFFFF, 32'd1, 0);
    clear_q();
    run_op("R4 sub equal", 4'd4, 32'd7, 32'd7, 0);
    run_op("R4 sub borrow", 4'd4, 32'd7, 32'd8, 0);
    clear_q();
  endtask

  task automatic t_wrap();
    run_op("R5 no ovf", 4'd5, 32'd100, 32'd23, 0);
    run_op("R5 ovf wraps", 4'd5, 32'h7FFFFFFF, 32'd1, 0);
    run_op("R5 neg ovf wraps", 4'd5, 32'h80000000, 32'h80000000, 0);
    clear_q();
  endtask

  task automatic t_narrow();
    int ws[4] = '{1, 8, 16, 31};
    foreach (ws[k]) begin
      longint lim;
      lim = longint'(1) << ws[k];
      run_op("R6 hi in",  4'd6, 32'(lim - 1), 0, 5'(ws[k]));
      run_op("R6 lo in",  4'd6, 32'(-lim), 0, 5'(ws[k]));
      if (ws[k] < 31) begin
        run_op("R6 hi out", 4'd6, 32'(lim), 0, 5'(ws[k]));
        run_op("R6 lo out", 4'd6, 32'(-lim - 1), 0, 5'(ws[k]));
      end
      run_op("R7 hi in",  4'd7, 32'(lim - 1), 0, 5'(ws[k]));
      run_op("R7 hi out", 4'd7, 32'(lim), 0, 5'(ws[k]));
      run_op("R7 zero",   4'd7, 32'd0, 0, 5'(ws[k]));
      run_op("R7 neg",    4'd7, 32'hFFFFFFFF, 0, 5'(ws[k]));
      clear_q();
    end
    run_op("R6 width zero", 4'd6, 32'd1, 0, 5'd0);
    clear_q();
  endtask

  task automatic t_pair();
    run_op("R8 signed both in", 4'd8, 32'h007F_FF80, 0, 5'd7);
    run_op("R8 signed hi clamps", 4'd8, 32'h0080_0005, 0, 5'd7);
    run_op("R8 signed lo clamps", 4'd8, 32'h0003_FF7F, 0, 5'd7);
    run_op("R8 unsigned mixed", 4'd9, 32'h8000_1234, 0, 5'd8);
    run_op("R8 unsigned in", 4'd9, 32'h00FF_0001, 0, 5'd8);
    run_op("R8 width 16", 4'd8, 32'h8000_7FFF, 0, 5'd16);
    clear_q();
  endtask

  task automatic t_flag_rules();
    // R9: a clamping value with op_en low leaves the flag at 0.
    @(negedge clk);
    op_sel = 4'd0; opnd_a = 32'h7FFFFFFF; opnd_b = 32'd1; op_en = 1'b0;
    @(negedge clk); #1;
    chk("R9 disabled no set", {31'b0, q_flag}, 32'd0);
    // R9: unused code gives zero and no event.
    run_op("R9 unused code", 4'd12, 32'h7FFFFFFF, 32'd1, 0);
    // R9: non-clamping ops keep a set flag.
    run_op("R9 set", 4'd3, 32'hFFFFFFFF, 32'd2, 0);
    run_op("R9 holds", 4'd0, 32'd1, 32'd1, 0);
    // R10: clear and event in the same cycle leaves the flag set.
    clear_q();
    @(negedge clk);
    op_sel = 4'd4; opnd_a = 32'd0; opnd_b = 32'd1; op_en = 1'b1; q_clr = 1'b1;
    @(negedge clk);
    op_en = 1'b0; q_clr = 1'b0; #1;
    chk("R10 clear loses to event", {31'b0, q_flag}, 32'd1);
    q_model = 1'b1;
    clear_q();
  endtask

  initial begin
    t_reset();
    t_sadd();
    t_ssub();
    t_dbl();
    t_unsigned();
    t_wrap();
    t_narrow();
    t_pair();
    t_flag_rules();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule